// File: doc/BRIEF.md
# Watermark FIFO with Error Interrupts

This block is a synchronous first-in first-out queue. It signals full to its producer when the number of stored entries reaches a programmable watermark, which can be lower than the physical storage depth. This lets a producer see back-pressure early, while the slots above the watermark stay free for words that are already in flight. The watermark is a 5-bit level input. A value of zero means the whole physical depth of 32 entries.

Misuse of the queue is recorded as an interrupt cause rather than silently lost. A push offered while the queue is full is refused, and it latches an overflow cause. A pop requested while the queue is empty latches an underflow cause. Six further cause bits capture single-cycle error strobes from neighbouring logic. All eight causes sit in one sticky status vector. Each cause has its own enable bit. A single interrupt line is high whenever any enabled cause is set. Software clears a cause by pulsing a one on its clear bit.

Both data sides use valid/ready handshakes. A word moves on the input side in a cycle where `in_valid` and `in_ready` are both high. A word moves on the output side in a cycle where `out_valid` and `out_ready` are both high. `in_ready` is low whenever the occupancy is at or above the effective watermark. `out_valid` is high whenever at least one word is stored. `out_data` shows the oldest word and holds steady until that word is popped. A producer may hold `in_valid` high while `in_ready` is low, but each such cycle counts as a push attempted while full. A consumer may hold `out_ready` high while `out_valid` is low, but each such cycle counts as a pop attempted while empty.

Top module: `wmark_fifo_irq`

## Requirements
- R1: After reset the queue is empty (`out_valid`=0, `fifo_empty`=1, `in_ready`=1, `fifo_full`=0), all eight status bits are 0 and `irq` is 0.
- R2: Words leave in the order in which they were accepted. This includes cycles that push and pop at the same time.
- R3: `in_ready` is low and `fifo_full` is high exactly when the occupancy is at least the effective watermark. The effective watermark is `wm_level`, except that 0 means 32.
- R4: A push attempted while full (`in_valid`=1, `in_ready`=0) stores nothing and leaves the stored words unchanged. On the next clock it sets status bit 0.
- R5: A pop attempted while empty (`out_ready`=1, `out_valid`=0) changes no stored state. On the next clock it sets status bit 1.
- R6: A set status bit stays set until a clock where its `irq_clr` bit is 1. A clear bit of 0 has no effect.
- R7: If a cause event and the clear of the same bit fall in the same clock, the bit stays set.
- R8: `ext_err[k]` high at a clock sets status bit k+2, for k from 0 to 5.
- R9: `irq` is 1 exactly when some status bit and the matching `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Queue below watermark, word will be taken |
| in_data | input | 8 | Word offered |
| out_valid | output | 1 | Oldest word is available |
| out_ready | input | 1 | Consumer takes the oldest word |
| out_data | output | 8 | Oldest stored word |
| fifo_full | output | 1 | Occupancy at or above effective watermark |
| fifo_empty | output | 1 | No word stored |
| wm_level | input | 5 | Watermark in entries, 0 selects 32 |
| ext_err | input | 6 | External error strobes for causes 2..7 |
| irq_en | input | 8 | Per-cause interrupt enable |
| irq_clr | input | 8 | Write-one-to-clear strobes, one per cause |
| irq_status | output | 8 | Sticky causes: bit0 overflow, bit1 underflow, bits 7..2 external |
| irq | output | 1 | OR of enabled causes |

## Verification
The hardest state to reach is a clock in which a cause event and a clear of that same cause happen together. The stimulus first lets the underflow bit latch. It then holds `out_ready` high on the empty queue while pulsing the clear of bit 1 in the same clock. The bench checks that the bit survives, and that a clear on a quiet clock removes it. The zero-watermark case is covered by filling all 32 physical slots. The bench watches `in_ready` fall only at the last slot, then drains the queue in order.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  localparam int unsigned NCAUSE   = 8;
  localparam int unsigned NEXT     = NCAUSE - 2;
  localparam int unsigned C_OVFL   = 0;
  localparam int unsigned C_UNDFL  = 1;
  localparam int unsigned C_EXT0   = 2;
  typedef logic [NCAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/wmf_occupancy.sv
module wmf_occupancy #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WM_W  = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  logic                         pop_req,
  input  logic [WM_W-1:0]              wm_level,
  output logic                         push_ok,
  output logic                         pop_ok,
  output logic                         push_err,
  output logic                         pop_err,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] limit;

  always_comb begin
    if (wm_level == '0 || 32'(wm_level) > DEPTH) limit = CW'(DEPTH);
    else                                          limit = CW'(wm_level);
  end

  assign full     = (count >= limit);
  assign empty    = (count == '0);
  assign push_ok  = push_req && !full;
  assign pop_ok   = pop_req && !empty;
  assign push_err = push_req && full;
  assign pop_err  = pop_req && empty;

  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= '0;
    else if (push_ok && !pop_ok) count <= count + 1'b1;
    else if (pop_ok && !push_ok) count <= count - 1'b1;
  end
endmodule

// File: rtl/wmf_irq.sv
module wmf_irq
  import wmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_vec_t cause_set,
  input  cause_vec_t cause_clr,
  input  cause_vec_t cause_en,
  output cause_vec_t status,
  output logic       irq
);
  for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= (status[i] && !cause_clr[i]) || cause_set[i];
    end
  end

  assign irq = |(status & cause_en);
endmodule

// File: rtl/wmark_fifo_irq.sv
module wmark_fifo_irq
  import wmf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned WM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic [WM_W-1:0]   wm_level,
  input  logic [NEXT-1:0]   ext_err,
  input  logic [NCAUSE-1:0] irq_en,
  input  logic [NCAUSE-1:0] irq_clr,
  output logic [NCAUSE-1:0] irq_status,
  output logic              irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          push_ok, pop_ok, push_err, pop_err, full_w, empty_w;
  logic [CW-1:0] occ_count;
  cause_vec_t    set_vec;

  wmf_occupancy #(.DEPTH(DEPTH), .WM_W(WM_W)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .push_req(in_valid), .pop_req(out_ready), .wm_level(wm_level),
    .push_ok(push_ok), .pop_ok(pop_ok), .push_err(push_err), .pop_err(pop_err),
    .full(full_w), .empty(empty_w), .count(occ_count)
  );

  wmf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_ok), .wr_data(in_data),
    .rd_en(pop_ok), .rd_data(out_data)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[C_OVFL]  = push_err;
    set_vec[C_UNDFL] = pop_err;
    set_vec[NCAUSE-1:C_EXT0] = ext_err;
  end

  wmf_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .cause_set(set_vec), .cause_clr(irq_clr), .cause_en(irq_en),
    .status(irq_status), .irq(irq)
  );

  assign in_ready   = !full_w;
  assign fifo_full  = full_w;
  assign out_valid  = !empty_w;
  assign fifo_empty = empty_w;
endmodule

// File: rtl/wmf_checker.sv
module wmf_checker #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [5:0]    ext_err,
  input logic [7:0]    irq_en,
  input logic [7:0]    irq_clr,
  input logic [7:0]    irq_status,
  input logic          irq,
  input logic [CW-1:0] occ_count
);
  a_r3_never_above_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_count >= CW'(DEPTH)) |-> !in_ready);

  a_r4_refused_push_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> irq_status[0]);

  a_r4_refused_push_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !(out_valid && out_ready)) |=> (occ_count == $past(occ_count)));

  a_r5_empty_pop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid) |=> irq_status[1]);

  a_r5_empty_pop_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !in_valid) |=> !out_valid);

  a_r2_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[0] && !irq_clr[0]) |=> irq_status[0]);

  a_r8_ext_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ext_err[0] |=> irq_status[2]);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 8'h00) |-> !irq);
endmodule

bind wmark_fifo_irq wmf_checker #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .ext_err(ext_err), .irq_en(irq_en), .irq_clr(irq_clr),
  .irq_status(irq_status), .irq(irq), .occ_count(occ_count)
);

// File: tb/sim_wmark_fifo_irq.sv
`timescale 1ns/1ps
module sim_wmark_fifo_irq;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, out_ready, in_ready, out_valid, fifo_full, fifo_empty, irq;
  logic [7:0] in_data, out_data, irq_en, irq_clr, irq_status;
  logic [4:0] wm_level;
  logic [5:0] ext_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wmark_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .wm_level(wm_level), .ext_err(ext_err), .irq_en(irq_en),
    .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
  );

  // step: push, pop, data, exp_empty, exp_full, exp_head (watermark 4)
  typedef struct packed {
    logic       push;
    logic       pop;
    logic [7:0] din;
    logic       e_empty;
    logic       e_full;
    logic [7:0] e_head;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 8'h11},
    '{1'b1, 1'b0, 8'h22, 1'b0, 1'b0, 8'h11},
    '{1'b1, 1'b0, 8'h33, 1'b0, 1'b0, 8'h11},
    '{1'b1, 1'b0, 8'h44, 1'b0, 1'b1, 8'h11},
    '{1'b1, 1'b0, 8'h55, 1'b0, 1'b1, 8'h11},
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h22},
    '{1'b1, 1'b1, 8'h66, 1'b0, 1'b0, 8'h33},
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h44},
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h66},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 8'h77}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle;
    in_valid = 0; out_ready = 0; irq_clr = '0; ext_err = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); in_data = '0; irq_en = '0; wm_level = 5'd4;
    tick(); tick();
    rst_n = 1;
    // R1 reset state
    chk("R1 empty", {out_valid, fifo_empty, in_ready, fifo_full}, 4'b0110);
    chk("R1 status", irq_status, 8'h00);
    chk("R1 irq", irq, 1'b0);

    // Table walk: R2 order, R3 watermark 4, R4 refused push, R5 empty pop
    for (int i = 0; i < NV; i++) begin
      in_valid = VT[i].push; out_ready = VT[i].pop; in_data = VT[i].din;
      tick();
      idle();
      chk("R3 full", fifo_full, VT[i].e_full);
      chk("R3 ready", in_ready, !VT[i].e_full);
      chk("R5 empty", fifo_empty, VT[i].e_empty);
      if (!VT[i].e_empty) chk("R2 head", out_data, VT[i].e_head);
    end
    // R4 and R5 causes latched by steps 5 and 11
    chk("R4 R5 status", irq_status, 8'h03);
    // R9 masking
    chk("R9 masked", irq, 1'b0);
    irq_en = 8'h01; #1;
    chk("R9 enabled", irq, 1'b1);
    // R6 clear bit0, zero-clear no effect
    irq_clr = 8'h01; tick(); idle();
    chk("R6 clear", irq_status, 8'h02);
    chk("R9 after clear", irq, 1'b0);
    tick();
    chk("R6 held", irq_status, 8'h02);
    // drain the 0x77 word
    out_ready = 1; tick(); idle();
    chk("R2 drained", fifo_empty, 1'b1);
    // R7 event and clear together on bit1
    out_ready = 1; irq_clr = 8'h02; tick(); idle();
    chk("R7 collide", irq_status, 8'h02);
    irq_clr = 8'h02; tick(); idle();
    chk("R6 clear2", irq_status, 8'h00);
    // R8 external causes
    ext_err = 6'b001000; tick(); idle();
    chk("R8 ext3", irq_status, 8'h20);
    irq_en = 8'h20; #1;
    chk("R9 ext irq", irq, 1'b1);
    irq_clr = 8'hFF; tick(); idle();
    chk("R8 cleared", irq_status, 8'h00);

    // R3 watermark 0 means 32 entries
    wm_level = 5'd0;
    for (int k = 0; k < 32; k++) begin
      chk("R3 ready below depth", in_ready, 1'b1);
      in_valid = 1; in_data = 8'(k + 8'h80); tick(); idle();
    end
    chk("R3 full at 32", {fifo_full, in_ready}, 2'b10);
    // R4 refused push keeps data
    in_valid = 1; in_data = 8'hEE; tick(); idle();
    chk("R4 overflow flag", irq_status, 8'h01);
    // lower watermark below occupancy keeps full
    wm_level = 5'd3; #1;
    chk("R3 lowered wm", fifo_full, 1'b1);
    wm_level = 5'd0;
    for (int k = 0; k < 32; k++) begin
      chk("R2 R4 drain order", out_data, 8'(k + 8'h80));
      out_ready = 1; tick(); idle();
    end
    chk("R4 no extra word", fifo_empty, 1'b1);

    // R1 reset mid-run
    in_valid = 1; in_data = 8'h5A; tick(); idle();
    ext_err = 6'h3F; tick(); idle();
    rst_n = 0; tick(); rst_n = 1;
    chk("R1 reset again", {fifo_empty, irq_status}, {1'b1, 8'h00});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule